// File: doc/BRIEF.md
# Multilevel Lookup-Table Adaptive Predistorter

This block pre-shapes baseband I/Q samples so that a following nonlinear power amplifier ends up with a near-linear overall response. Each sample is multiplied by a complex gain. The gain is the sum of one entry from each of seven parallel tables, whose sizes are 1, 2, 4, 8, 16, 32 and 64 entries. Every table is indexed by the sample's estimated amplitude, quantized to that table's resolution. The coarse tables are visited often and pull the gain curve into shape quickly. The fine tables set the final accuracy.

Adaptation is LMS. One cycle after a sample is accepted, the caller presents the matching amplifier feedback, already aligned in time and scaled back. The error between the stored input and that feedback, times the conjugate of the input, is scaled down and added to the one cell read in every table. Updates run only while adaptation is enabled. After reset the block is transparent.

Top module: `mlut_predistorter`

## Requirements
- R1: During reset `out_valid` and the outputs are 0. After reset the gain is exactly 1+0j (the 1-entry table holds 4096+0j, every other cell is 0), so each output equals its input.
- R2: A sample accepted with `in_valid` appears on `out_i`/`out_q` with `out_valid` one cycle later. The outputs are sat10(((x·g) >>> 12)), where x is the 10-bit signed input, g the 14-bit signed gain with 4096 = 1.0, and >>> an arithmetic (floor) shift. Outputs hold while `in_valid` is low.
- R3: The amplitude is max(|I|,|Q|) + floor(min(|I|,|Q|)/2), limited to 511 (9 bits). The table with 2^k entries (k = 0..6) is indexed by the top k bits of that 9-bit amplitude.
- R4: In a cycle where `out_valid` and `adapt_en` are both high, the block samples `fb_i`/`fb_q` as the feedback for the pending sample x. With e = x − fb, pI = eI·xI + eQ·xQ and pQ = eQ·xI − eI·xQ, every table's cell at that sample's address gains d = (p + 1024) >>> 11 in each part. This is a step of 1/32 per table.
- R5: When that rounded step is 0, the cell keeps its value (stalling). Small errors therefore leave the gain unchanged.
- R6: With `adapt_en` low, the feedback has no effect and no cell changes.
- R7: Cell updates and the seven-entry gain sum saturate to [−8192, 8191]. Outputs saturate to [−512, 511]. Nothing wraps.
- R8: A sample accepted in the same cycle as an update is computed from the cell values before that update, for back-to-back streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 10 | Input in-phase, signed |
| in_q | input | 10 | Input quadrature, signed |
| adapt_en | input | 1 | Enables table adaptation |
| fb_i | input | 10 | Aligned feedback in-phase, valid with `out_valid` |
| fb_q | input | 10 | Aligned feedback quadrature, valid with `out_valid` |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 10 | Predistorted in-phase, signed |
| out_q | output | 10 | Predistorted quadrature, signed |

## Verification
The table read for a new sample and the table write for the previous sample's feedback can land in the same cycle and on the same cells. The bench provokes this with an unbroken stream of equal-amplitude samples, all with adaptation on and zero feedback, so every update is large and hits the cells being read. Each output is judged against a reference that computes the sample from the table state first and applies the pending update afterwards. A read that sees the new value, or an update that goes missing, shows up as an output mismatch.

// File: rtl/mlut_predistorter.sv
module mlut_predistorter #(
  parameter int DW        = 10,
  parameter int GW        = 14,
  parameter int NLEV      = 7,
  parameter int MU_SHIFT  = 5,
  parameter int ONE_SHIFT = 12
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 adapt_en,
  input  logic signed [DW-1:0] fb_i,
  input  logic signed [DW-1:0] fb_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int AW    = DW - 1;
  localparam int NCELL = (1 << NLEV) - 1;
  localparam int IW    = NLEV;
  localparam int PW    = DW + GW + 1;
  localparam int RSH   = 2 * AW - ONE_SHIFT + MU_SHIFT;
  localparam int AMAX  = (1 << AW) - 1;

  localparam logic signed [PW-1:0] GMAX_P = PW'((1 << (GW - 1)) - 1);
  localparam logic signed [PW-1:0] GMIN_P = -PW'(1 << (GW - 1));
  localparam logic signed [PW-1:0] OMAX_P = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] OMIN_P = -PW'(1 << (DW - 1));
  localparam logic signed [PW-1:0] RND_P  = PW'(1 << (RSH - 1));
  localparam logic signed [GW-1:0] UNITY  = GW'(1 << ONE_SHIFT);

  function automatic logic signed [PW-1:0] sx(input logic signed [DW-1:0] v);
    return {{(PW-DW){v[DW-1]}}, v};
  endfunction

  function automatic logic signed [PW-1:0] sgx(input logic signed [GW-1:0] v);
    return {{(PW-GW){v[GW-1]}}, v};
  endfunction

  function automatic logic signed [GW-1:0] sat_g(input logic signed [PW-1:0] v);
    if (v > GMAX_P) return GMAX_P[GW-1:0];
    if (v < GMIN_P) return GMIN_P[GW-1:0];
    return v[GW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] sat_o(input logic signed [PW-1:0] v);
    if (v > OMAX_P) return OMAX_P[DW-1:0];
    if (v < OMIN_P) return OMIN_P[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic signed [GW-1:0] cell_i [NCELL];
  logic signed [GW-1:0] cell_q [NCELL];

  // amplitude estimate
  logic [DW-1:0] abs_i, abs_q, a_big, a_small;
  logic [DW:0]   a_raw;
  logic [AW-1:0] amp;

  assign abs_i   = in_i[DW-1] ? $unsigned(-in_i) : $unsigned(in_i);
  assign abs_q   = in_q[DW-1] ? $unsigned(-in_q) : $unsigned(in_q);
  assign a_big   = (abs_i > abs_q) ? abs_i : abs_q;
  assign a_small = (abs_i > abs_q) ? abs_q : abs_i;
  assign a_raw   = {1'b0, a_big} + {1'b0, a_small >> 1};
  assign amp     = (a_raw > (DW+1)'(AMAX)) ? AW'(AMAX) : a_raw[AW-1:0];

  logic [IW-1:0] rd_idx [NLEV];
  always_comb
    for (int k = 0; k < NLEV; k++)
      rd_idx[k] = IW'((1 << k) - 1) + IW'(amp >> (AW - k));

  // summed complex gain
  logic signed [PW-1:0] acc_i, acc_q;
  logic signed [GW-1:0] g_i, g_q;
  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < NLEV; k++) begin
      acc_i = acc_i + sgx(cell_i[rd_idx[k]]);
      acc_q = acc_q + sgx(cell_q[rd_idx[k]]);
    end
  end
  assign g_i = sat_g(acc_i);
  assign g_q = sat_g(acc_q);

  logic signed [PW-1:0] y_i, y_q;
  assign y_i = sx(in_i) * sgx(g_i) - sx(in_q) * sgx(g_q);
  assign y_q = sx(in_i) * sgx(g_q) + sx(in_q) * sgx(g_i);

  // pending sample for the update
  logic signed [DW-1:0] xr_i, xr_q;
  logic [IW-1:0]        wr_idx [NLEV];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      xr_i      <= '0;
      xr_q      <= '0;
      for (int k = 0; k < NLEV; k++) wr_idx[k] <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= sat_o(y_i >>> ONE_SHIFT);
        out_q <= sat_o(y_q >>> ONE_SHIFT);
        xr_i  <= in_i;
        xr_q  <= in_q;
        for (int k = 0; k < NLEV; k++) wr_idx[k] <= rd_idx[k];
      end
    end

  // LMS update
  logic                 wr;
  logic signed [PW-1:0] e_i, e_q, p_i, p_q, d_i, d_q;

  assign wr  = out_valid & adapt_en;
  assign e_i = sx(xr_i) - sx(fb_i);
  assign e_q = sx(xr_q) - sx(fb_q);
  assign p_i = e_i * sx(xr_i) + e_q * sx(xr_q);
  assign p_q = e_q * sx(xr_i) - e_i * sx(xr_q);
  assign d_i = (p_i + RND_P) >>> RSH;
  assign d_q = (p_q + RND_P) >>> RSH;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int c = 0; c < NCELL; c++) begin
        cell_i[c] <= '0;
        cell_q[c] <= '0;
      end
      cell_i[0] <= UNITY;
    end else if (wr) begin
      for (int k = 0; k < NLEV; k++) begin
        cell_i[wr_idx[k]] <= sat_g(sgx(cell_i[wr_idx[k]]) + d_i);
        cell_q[wr_idx[k]] <= sat_g(sgx(cell_q[wr_idx[k]]) + d_q);
      end
    end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_i) && $stable(out_q) && !out_valid);
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !adapt_en) |=> $stable(cell_i[0]) && $stable(cell_q[0]));
  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && d_i == '0 && d_q == '0) |=> $stable(cell_i[0]) && $stable(cell_q[0]));
  assert_step_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && d_i > '0) |=> cell_i[0] >= $past(cell_i[0]));

endmodule

// File: tb/mlut_predistorter_bench.sv
module mlut_predistorter_bench;
  localparam int NC = 127;
  localparam int NL = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, adapt_en = 1'b0;
  logic signed [9:0] in_i = '0, in_q = '0, fb_i = '0, fb_q = '0;
  logic out_valid;
  logic signed [9:0] out_i, out_q;

  always #5 clk = ~clk;

  mlut_predistorter u_mlut_predistorter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .adapt_en(adapt_en), .fb_i(fb_i), .fb_q(fb_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  int mi[NC], mq[NC];
  int n_chk = 0, n_fail = 0;
  bit pend = 0;
  int px_i, px_q, pa;

  function automatic int satv(int v, int lo, int hi);
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  function automatic int amp_of(int i, int q);
    int ai = (i < 0) ? -i : i;
    int aq = (q < 0) ? -q : q;
    int mx = (ai > aq) ? ai : aq;
    int mn = (ai > aq) ? aq : ai;
    return satv(mx + mn / 2, 0, 511);
  endfunction

  function automatic int cidx(int a, int k);
    return (1 << k) - 1 + (a >> (9 - k));
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin mi[c] = 0; mq[c] = 0; end
    mi[0] = 4096;
    pend = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; adapt_en = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset out_i", out_i, 0);
    check("R1 reset out_q", out_q, 0);
    rst_n = 1'b1;
  endtask

  // one cycle: new sample (v), feedback for the pending sample (fi,fq), adapt flag
  task automatic cyc(bit v, int xi, int xq, int fi, int fq, bit ad, string req);
    int a, gi, gq, yi, yq;
    @(negedge clk);
    in_valid = v; in_i = 10'(xi); in_q = 10'(xq);
    fb_i = 10'(fi); fb_q = 10'(fq); adapt_en = ad;
    a = amp_of(xi, xq);
    gi = 0; gq = 0;
    for (int k = 0; k < NL; k++) begin
      gi += mi[cidx(a, k)];
      gq += mq[cidx(a, k)];
    end
    gi = satv(gi, -8192, 8191);
    gq = satv(gq, -8192, 8191);
    yi = satv((xi * gi - xq * gq) >>> 12, -512, 511);
    yq = satv((xi * gq + xq * gi) >>> 12, -512, 511);
    if (pend && ad) begin
      int ei = px_i - fi, eq = px_q - fq;
      int di = (ei * px_i + eq * px_q + 1024) >>> 11;
      int dq = (eq * px_i - ei * px_q + 1024) >>> 11;
      for (int k = 0; k < NL; k++) begin
        int c = cidx(pa, k);
        mi[c] = satv(mi[c] + di, -8192, 8191);
        mq[c] = satv(mq[c] + dq, -8192, 8191);
      end
    end
    @(posedge clk); #1;
    check(req, out_valid, v);
    if (v) begin
      check(req, out_i, yi);
      check(req, out_q, yq);
    end
    pend = v; px_i = xi; px_q = xq; pa = a;
  endtask

  task automatic probe(int xi, int xq, string req);
    cyc(1, xi, xq, 0, 0, 0, req);
    cyc(0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic t_transparent();
    do_reset();
    probe(100, -37, "R1 transparent");
    probe(-512, -512, "R1 R3 full-scale");
    probe(511, 511, "R1 R3 saturated amplitude");
    probe(0, 0, "R1 zero");
    probe(-300, 250, "R1 mixed");
    cyc(1, 7, -1, 0, 0, 0, "R2 latency");
    cyc(0, 0, 0, 0, 0, 0, "R2 hold");
    check("R2 held out_i", out_i, 7);
  endtask

  task automatic t_adapt_once();
    do_reset();
    cyc(1, 400, 100, 0, 0, 0, "R4 train");
    cyc(0, 0, 0, 300, 80, 1, "R4 feedback");
    probe(400, 100, "R4 same cell");
    probe(100, 400, "R3 swapped I/Q same amplitude");
    probe(390, 100, "R3 neighbour fine cell");
    probe(50, 20, "R3 low amplitude coarse only");
  endtask

  task automatic t_stall();
    do_reset();
    cyc(1, 200, 0, 0, 0, 0, "R5 train");
    cyc(0, 0, 0, 199, 0, 1, "R5 tiny error");
    probe(200, 0, "R5 stalled gain");
    check("R5 output unchanged", out_i, 200);
  endtask

  task automatic t_frozen();
    do_reset();
    cyc(1, 500, 0, 0, 0, 0, "R6 train");
    cyc(0, 0, 0, 0, 0, 0, "R6 feedback ignored");
    probe(500, 0, "R6 no update");
    check("R6 output unchanged", out_i, 500);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int n = 0; n < 80; n++) begin
      cyc(1, 511, 0, 0, 0, 0, "R7 drive");
      cyc(0, 0, 0, 0, 0, 1, "R7 update");
    end
    probe(511, 0, "R7 output clipped");
    check("R7 clip value", out_i, 511);
    probe(-256, 0, "R7 negative clipped");
    check("R7 negative clip value", out_i, -512);
  endtask

  task automatic t_back2back();
    do_reset();
    for (int n = 0; n < 20; n++) cyc(1, 300, 0, 0, 0, 1, "R8 read before write");
    cyc(0, 0, 0, 0, 0, 1, "R8 last update");
    probe(300, 0, "R8 final state");
  endtask

  initial begin
    #(2_000_000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    t_transparent();
    t_adapt_once();
    t_stall();
    t_frozen();
    t_saturate();
    t_back2back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule